// File: doc/BRIEF.md
# Transition Pulse Encoder with Refresh

This block is the sending half of a digital isolation channel whose link carries only short pulses, never levels. It synchronizes one logic input into the local clock domain. Each change of that input is turned into a strobe on one of two outputs: a set strobe when the input becomes high, and a reset strobe when it becomes low. A receiver that latches on set and clears on reset can therefore rebuild the level.

Pulses alone cannot keep the far side correct when the input sits still, and a lost pulse would never be corrected. So the block restates the current level after a fixed number of quiet cycles, using the same set or reset strobe. A supply-good input from an undervoltage detector gates everything. While it is low, no strobe leaves the block and all pulse and timer state is dropped. When it rises, the block sends the present level at once, whether or not the far side is already powered.

Pulse width, refresh interval and synchronizer depth are parameters counted in clock cycles.

Top module: `pulse_edge_encoder`

## Requirements
- R1: While rst_n is low, setPulse and resetPulse are both low.
- R2: When dataIn changes from 0 to 1 and no pulse is in progress, setPulse goes high on the third rising clock edge after the change (two synchronizer flops plus the output register) and stays high for exactly PULSE_W cycles.
- R3: When dataIn changes from 1 to 0 and no pulse is in progress, resetPulse goes high with the same latency as in R2 and stays high for exactly PULSE_W cycles.
- R4: setPulse and resetPulse are never high in the same cycle.
- R5: When REFRESH_CYCLES clock edges pass after the start of the last pulse and the input has not changed, a refresh pulse starts. It is setPulse if the synchronized level is 1 and resetPulse if it is 0, and it is PULSE_W cycles wide.
- R6: Every pulse start, whether it comes from an edge, a refresh or supply release, restarts the refresh interval from zero.
- R7: On the clock edge that samples supplyOk low, both outputs drop to 0, cutting short any pulse in progress. While supplyOk stays low, input changes produce no pulse.
- R8: On the first clock edge with supplyOk high after it was low, or after reset is released, a pulse carrying the current synchronized level starts. No input change is needed.
- R9: Input changes seen while a pulse is in progress are not lost and not queued as events. When the pulse ends, the synchronized level is compared with the last level sent, and a pulse is sent only if they differ. A change that reverts during the pulse therefore produces nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supplyOk | input | 1 | High when the local supply is above the undervoltage threshold |
| dataIn | input | 1 | Logic input to be carried across the barrier (asynchronous) |
| setPulse | output | 1 | Strobe meaning "far side goes high" |
| resetPulse | output | 1 | Strobe meaning "far side goes low" |

## Verification
The bench builds the encoder with a three-cycle pulse and a 24-cycle refresh interval. The wide pulse makes the busy window of R9 long enough to fit a glitch that reverts inside it. The short interval lets many refresh cycles, and their interaction with edges that arrive just before a refresh is due, happen within a short run. Supply drops of random length land in the middle of pulses and quiet periods alike, so the truncation of R7 and the restart pulse of R8 are seen from many starting states.

// File: rtl/pulse_edge_pkg.sv
package pulse_edge_pkg;

  // Command from control to datapath for one clock cycle.
  // load: start a pulse carrying the present synchronized level
  // hold: keep the pulse currently on the outputs
  // neither: drive both outputs low
  typedef struct packed {
    logic load;
    logic hold;
  } encStrobe_t;

endpackage

// File: rtl/pulse_edge_path.sv
module pulse_edge_path
  import pulse_edge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dataIn,
  input  encStrobe_t strobe,
  output logic       levelNow,
  output logic       changed,
  output logic       setPulse,
  output logic       resetPulse
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic sentLevel;
  logic setReg;
  logic resetReg;

  // synchronizer stages, first one fed by the asynchronous input
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : gSync
    if (i == 0) begin : gHead
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncChain[i] <= 1'b0;
        else        syncChain[i] <= dataIn;
      end
    end else begin : gTail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncChain[i] <= 1'b0;
        else        syncChain[i] <= syncChain[i-1];
      end
    end
  end

  assign levelNow = syncChain[SYNC_STAGES-1];
  assign changed  = levelNow ^ sentLevel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sentLevel <= 1'b0;
      setReg    <= 1'b0;
      resetReg  <= 1'b0;
    end else if (strobe.load) begin
      sentLevel <= levelNow;
      setReg    <= levelNow;
      resetReg  <= ~levelNow;
    end else if (!strobe.hold) begin
      setReg    <= 1'b0;
      resetReg  <= 1'b0;
    end
  end

  assign setPulse   = setReg;
  assign resetPulse = resetReg;

  assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(setPulse && resetPulse));

  // a set strobe only ever carries a high level, a reset strobe a low one
  assert_set_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    setPulse |-> sentLevel);

  assert_reset_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resetPulse |-> !sentLevel);

endmodule

// File: rtl/pulse_edge_ctrl.sv
module pulse_edge_ctrl
  import pulse_edge_pkg::*;
#(
  parameter int PULSE_W        = 1,
  parameter int REFRESH_CYCLES = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supplyOk,
  input  logic       changed,
  output encStrobe_t strobe
);

  localparam int REM_W   = $clog2(PULSE_W + 1);
  localparam int QUIET_W = $clog2(REFRESH_CYCLES + 1);
  localparam logic [REM_W-1:0]   REM_LOAD  = REM_W'(PULSE_W - 1);
  localparam logic [QUIET_W-1:0] QUIET_END = QUIET_W'(REFRESH_CYCLES - 1);

  logic [REM_W-1:0]   remainCnt;
  logic [QUIET_W-1:0] quietCnt;
  logic primed;
  logic busy;
  logic fire;

  assign busy = (remainCnt != '0);
  assign fire = supplyOk && !busy && (!primed || changed || quietCnt == QUIET_END);

  always_comb begin
    strobe.load = fire;
    strobe.hold = supplyOk && busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remainCnt <= '0;
      quietCnt  <= '0;
      primed    <= 1'b0;
    end else if (!supplyOk) begin
      remainCnt <= '0;
      quietCnt  <= '0;
      primed    <= 1'b0;
    end else if (fire) begin
      remainCnt <= REM_LOAD;
      quietCnt  <= '0;
      primed    <= 1'b1;
    end else begin
      if (busy) remainCnt <= remainCnt - 1'b1;
      if (quietCnt != QUIET_END) quietCnt <= quietCnt + 1'b1;
    end
  end

  assert_quiet_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    quietCnt <= QUIET_END);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> (quietCnt == '0));

endmodule

// File: rtl/pulse_edge_encoder.sv
module pulse_edge_encoder
  import pulse_edge_pkg::*;
#(
  parameter int PULSE_W        = 1,
  parameter int REFRESH_CYCLES = 100,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supplyOk,
  input  logic dataIn,
  output logic setPulse,
  output logic resetPulse
);

  encStrobe_t strobe;
  logic levelNow;
  logic changed;

  pulse_edge_ctrl #(
    .PULSE_W        (PULSE_W),
    .REFRESH_CYCLES (REFRESH_CYCLES)
  ) uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .supplyOk (supplyOk),
    .changed  (changed),
    .strobe   (strobe)
  );

  pulse_edge_path #(
    .SYNC_STAGES (SYNC_STAGES)
  ) uPath (
    .clk        (clk),
    .rst_n      (rst_n),
    .dataIn     (dataIn),
    .strobe     (strobe),
    .levelNow   (levelNow),
    .changed    (changed),
    .setPulse   (setPulse),
    .resetPulse (resetPulse)
  );

  assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !supplyOk |=> !(setPulse || resetPulse));

  assert_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> (setPulse == levelNow_q) && (resetPulse == !levelNow_q));

  logic levelNow_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) levelNow_q <= 1'b0;
    else        levelNow_q <= levelNow;
  end

endmodule

// File: tb/pulse_edge_encoder_test.sv
module pulse_edge_encoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int PW  = 3;
  localparam int REF = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supplyOk = 1'b1;
  logic dataIn = 1'b0;
  logic setPulse;
  logic resetPulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_edge_encoder #(
    .PULSE_W        (PW),
    .REFRESH_CYCLES (REF),
    .SYNC_STAGES    (2)
  ) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .supplyOk   (supplyOk),
    .dataIn     (dataIn),
    .setPulse   (setPulse),
    .resetPulse (resetPulse)
  );

  // ---------------- reference model built from the requirements ----------------
  typedef enum int {C_IDLE, C_FIRST, C_EDGE, C_REFRESH, C_GATED} cause_t;
  bit m1, m2, mSent, mSet, mRst, mPrimed;
  int mRem, mQuiet;
  cause_t mCause;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 = 0; m2 = 0; mSent = 0; mSet = 0; mRst = 0; mPrimed = 0;
      mRem = 0; mQuiet = 0; mCause = C_IDLE;
    end else begin
      if (!supplyOk) begin
        mSet = 0; mRst = 0; mRem = 0; mQuiet = 0; mPrimed = 0; mCause = C_GATED;
      end else if (mRem == 0 && (!mPrimed || m2 != mSent || mQuiet == REF - 1)) begin
        mCause = !mPrimed ? C_FIRST : (m2 != mSent ? C_EDGE : C_REFRESH);
        mSet = m2; mRst = !m2; mSent = m2; mRem = PW - 1; mQuiet = 0; mPrimed = 1;
      end else begin
        if (mRem != 0) mRem = mRem - 1;
        else begin mSet = 0; mRst = 0; mCause = C_IDLE; end
        if (mQuiet != REF - 1) mQuiet = mQuiet + 1;
      end
      m2 = m1; m1 = dataIn;
    end
  end

  function automatic string tagOf(cause_t c, bit s);
    case (c)
      C_FIRST:   return "R8";
      C_EDGE:    return s ? "R2" : "R3";
      C_REFRESH: return "R5";
      C_GATED:   return "R7";
      default:   return "R6,R9";
    endcase
  endfunction

  // cycle-by-cycle comparison, also covers R4 since the model never sets both
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (setPulse !== mSet || resetPulse !== mRst) begin
        errors++;
        $display("FAIL %s model: set=%0b reset=%0b expected set=%0b reset=%0b at %0t",
                 tagOf(mCause, mSet), setPulse, resetPulse, mSet, mRst, $time);
      end
      if (setPulse && resetPulse) begin
        checks++; errors++;
        $display("FAIL R4 both strobes high: set=%0b reset=%0b expected not both", setPulse, resetPulse);
      end
    end
  end

  task automatic expectNow(string tag, bit eSet, bit eRst);
    checks++;
    if (setPulse !== eSet || resetPulse !== eRst) begin
      errors++;
      $display("FAIL %s directed: set=%0b reset=%0b expected set=%0b reset=%0b at %0t",
               tag, setPulse, resetPulse, eSet, eRst, $time);
    end
  endtask

  task automatic waitNeg(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: outputs quiet during reset
    waitNeg(3);
    expectNow("R1", 0, 0);
    rst_n = 1'b1;
    // R8: first cycle after reset release sends current level (0)
    waitNeg(1);
    expectNow("R8", 0, 1);

    // R2: rising edge, three edges of latency
    waitNeg(10);
    dataIn = 1'b1;
    waitNeg(3);
    expectNow("R2", 1, 0);
    waitNeg(2);
    expectNow("R2", 1, 0);
    waitNeg(1);
    expectNow("R2", 0, 0);
    // R5: refresh REF edges after the set pulse start
    waitNeg(REF - 4);
    expectNow("R5", 0, 0);
    waitNeg(1);
    expectNow("R5", 1, 0);

    // R3: falling edge
    waitNeg(5);
    dataIn = 1'b0;
    waitNeg(3);
    expectNow("R3", 0, 1);
    // R6: a new edge restarts the interval
    waitNeg(10);
    dataIn = 1'b1;
    waitNeg(3);
    expectNow("R2", 1, 0);
    for (int k = 1; k <= REF; k++) begin
      @(negedge clk);
      if (k < PW)       expectNow("R6", 1, 0);
      else if (k < REF) expectNow("R6", 0, 0);
      else              expectNow("R5", 1, 0);
    end

    // R7: supply drop in the middle of a pulse
    supplyOk = 1'b0;
    waitNeg(1);
    expectNow("R7", 0, 0);
    for (int k = 0; k < 30; k++) begin
      if (k % 3 == 0) dataIn = ~dataIn;
      @(negedge clk);
      expectNow("R7", 0, 0);
    end
    dataIn = 1'b1;
    waitNeg(3);
    supplyOk = 1'b1;
    waitNeg(1);
    expectNow("R8", 1, 0);

    // R9: glitch that reverts during the busy window is swallowed
    waitNeg(5);
    dataIn = 1'b0;
    waitNeg(2);
    dataIn = 1'b1;
    waitNeg(1);
    expectNow("R3", 0, 1);
    dataIn = 1'b0;
    waitNeg(2);
    expectNow("R3", 0, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      expectNow("R9", 0, 0);
    end

    // constrained random phase, checked by the model every cycle
    for (int it = 0; it < 2500; it++) begin
      if ($urandom_range(0, 14) == 0) begin
        supplyOk = 1'b0;
        waitNeg($urandom_range(1, 10));
        supplyOk = 1'b1;
      end
      if ($urandom_range(0, 2) != 0) dataIn = ~dataIn;
      waitNeg($urandom_range(1, 40));
    end

    waitNeg(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule